// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block sends an 8-bit companded voice sample over a serial line that can be placed in high impedance. Three slow external strobes drive it, and all three are sampled on the system clock. The first is a data clock, whose rising edges advance the line to the next bit. The second is an enable, which drives the line and permits shifting while it is high. The third is a frame sync, which arms the port so that it accepts a new sample.

The first enable rising edge after a sync rising edge produces a one-cycle conversion strobe. At that edge the parallel sample is copied into a rotating register and the sign bit is placed on the line at once. After that, each data-clock rise that arrives while the enable is high shows the next lower bit. When the last bit has gone out, the word wraps around to its sign bit again, so a host can read it more than once. A host may also drop the enable between bits and raise it again later. This gives a bit-interleaved slot, and shifting picks up where it stopped.

The parallel sample input has no handshake. It is read only in the cycle in which the strobe is raised, so the strobe is the only flow control the port has. The converter must keep the word valid whenever an enable rise can occur. The host must leave at least two data-clock falling edges between frames. It must also hold each data-clock and enable level for at least `SYNC_STAGES + 1` system clocks.

Top module: `pcm_tx_port`

## Requirements
- R1: While reset is held, the serial data, its output enable and the conversion strobe are all 0.
- R2: The first enable rise after a sync rise raises the conversion strobe for exactly one system clock. In that same cycle it loads the parallel sample.
- R3: An enable rise with no sync rise since the last load raises no strobe and does not reload the register. Shifting continues from the bit that was last shown.
- R4: Right after a load, the serial data equals bit 7 of the sample (the sign bit).
- R5: Each data-clock rise that comes while the enable is high moves the line to the next lower bit. Data-clock rises while the enable is low leave the line unchanged.
- R6: The output enable follows the synchronised enable level. The serial data is only meaningful while it is 1.
- R7: After eight shifts the line shows bit 7 of the same word again, and the whole word repeats.
- R8: With the default two-stage synchroniser, an enable edge that the bench drives between clock edges shows up on the output enable and the strobe at the third following rising clock edge. It does not show up earlier.
- R9: A sync rise with no enable rise produces no strobe. A sync rise and an enable rise that arrive in the same cycle do produce a strobe and a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dclk_i | input | 1 | Serial data clock (asynchronous) |
| ten_i | input | 1 | Transmit enable (asynchronous) |
| sync_i | input | 1 | Frame sync (asynchronous) |
| pcm_word_i | input | WORD_W | Companded sample, read when the strobe fires |
| sdo_o | output | 1 | Serial data, sign bit first |
| sdo_oe_o | output | 1 | Drive enable for the serial pad |
| conv_strobe_o | output | 1 | One-cycle load and conversion-request pulse |

## Verification
The bench goes after five corner cases.

- **Re-raised enable.** It raises the enable a second time with no sync in between. A port that reloaded on every enable rise would restart at the new word's sign bit and pulse the strobe again.
- **Bit-interleaved shifting.** It toggles the enable between single bits and pulses the data clock while the enable is low. A port that shifted on the clock alone would skip bits.
- **Coincident sync and enable.** It makes a sync rise and an enable rise arrive together. A port that needed the arm flag to be set first would miss that frame.
- **Wrap-around.** It checks the ninth bit position. A port that shifted in zeros instead of recirculating would show 0 there instead of the sign bit.
- **Latency.** It counts clock edges to the first change on the output enable, which catches an added or missing pipeline stage.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  // Positions of the sampled control pins inside the synchroniser vector
  localparam int PIN_DCLK  = 0;
  localparam int PIN_TEN   = 1;
  localparam int PIN_SYNC  = 2;
  localparam int PIN_COUNT = 3;
endpackage

// File: rtl/pcm_tx_sync.sv
module pcm_tx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  // One flop chain per pin, plus one extra flop holding the previous level
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[i]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl_o[i]  = chain[STAGES-1];
    assign prev_o[i] = last;
  end
endmodule

// File: rtl/pcm_tx_strobe.sv
module pcm_tx_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ten_rise_i,
  input  logic sync_rise_i,
  output logic fire_o,
  output logic strobe_o
);
  logic armed;

  // A sync rise in the same cycle as the enable rise counts as armed
  assign fire_o = ten_rise_i & (armed | sync_rise_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= fire_o;
      if (fire_o)
        armed <= 1'b0;
      else if (sync_rise_i)
        armed <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_shreg.sv
module pcm_tx_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] din_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] sreg;

  // The loaded word wins over a shift that lands in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)
      sreg <= '0;
    else if (load_i)
      sreg <= din_i;
    else if (shift_i)
      sreg <= {sreg[WIDTH-2:0], sreg[WIDTH-1]};
  end

  assign msb_o = sreg[WIDTH-1];
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk_i,
  input  logic              ten_i,
  input  logic              sync_i,
  input  logic [WORD_W-1:0] pcm_word_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              conv_strobe_o
);
  logic [PIN_COUNT-1:0] pin_raw, pin_lvl, pin_prev, pin_rise;
  logic fire, shift_en, oe_q;

  assign pin_raw[PIN_DCLK] = dclk_i;
  assign pin_raw[PIN_TEN]  = ten_i;
  assign pin_raw[PIN_SYNC] = sync_i;

  pcm_tx_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pin_raw),
    .lvl_o  (pin_lvl),
    .prev_o (pin_prev)
  );

  assign pin_rise = pin_lvl & ~pin_prev;

  // A bit advances only when a data-clock rise meets a high enable
  assign shift_en = pin_rise[PIN_DCLK] & pin_lvl[PIN_TEN];

  pcm_tx_strobe u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .ten_rise_i  (pin_rise[PIN_TEN]),
    .sync_rise_i (pin_rise[PIN_SYNC]),
    .fire_o      (fire),
    .strobe_o    (conv_strobe_o)
  );

  pcm_tx_shreg #(.WIDTH(WORD_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (fire),
    .shift_i (shift_en),
    .din_i   (pcm_word_i),
    .msb_o   (sdo_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= pin_lvl[PIN_TEN];
  end
  assign sdo_oe_o = oe_q;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic conv_strobe_o,
  input logic word_msb
);
  // R2: the strobe lasts exactly one cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe_o |=> !conv_strobe_o);

  // R6: a load only happens with the pad driven
  a_r6_strobe_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe_o |-> sdo_oe_o);

  // R4: the sign bit of the sampled word is on the line right after a load
  a_r4_sign_first: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe_o |-> (sdo_o == $past(word_msb)));

  // R5: with the enable low the line does not move
  a_r5_hold_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe_o |-> $stable(sdo_o));
endmodule

bind pcm_tx_port pcm_tx_port_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sdo_o         (sdo_o),
  .sdo_oe_o      (sdo_oe_o),
  .conv_strobe_o (conv_strobe_o),
  .word_msb      (pcm_word_i[WORD_W-1])
);

// File: tb/sim_pcm_tx_port.sv
module sim_pcm_tx_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dclk = 1'b0;
  logic       ten = 1'b0;
  logic       msync = 1'b0;
  logic [7:0] word = 8'h00;
  logic       sdo, sdo_oe, strobe;

  int total = 0;
  int bad = 0;
  int strobe_cnt = 0;

  typedef struct {
    logic  v;
    string req;
  } exp_t;
  exp_t exp_q[$];
  event smp;

  logic [7:0] mword = 8'h00;
  int midx = 7;

  always #10 clk = ~clk;

  pcm_tx_port u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .dclk_i        (dclk),
    .ten_i         (ten),
    .sync_i        (msync),
    .pcm_word_i    (word),
    .sdo_o         (sdo),
    .sdo_oe_o      (sdo_oe),
    .conv_strobe_o (strobe)
  );

  always @(posedge clk) if (rst_n && strobe) strobe_cnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard driver side: queue the expected bit and wake the monitor
  task automatic expect_bit(input string req);
    exp_q.push_back('{mword[midx], req});
    -> smp;
  endtask

  // Monitor: compares the line with each queued expectation
  initial begin
    forever begin
      @(smp);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(sdo === e.v, e.req, "serial bit", int'(sdo), int'(e.v));
      end
    end
  end

  task automatic dpulse(input string req);
    dclk = 1'b1;
    idle(4);
    dclk = 1'b0;
    idle(4);
    if (ten) midx = (midx == 0) ? 7 : midx - 1;
    expect_bit(req);
  endtask

  // Raise the enable on an armed port and check latency, strobe and sign bit
  task automatic ten_up_load(input logic [7:0] w, input string req);
    int c0;
    c0 = strobe_cnt;
    word = w;
    ten = 1'b1;
    idle(2);
    check(sdo_oe == 1'b0, "R8", "oe before 3rd edge", int'(sdo_oe), 0);
    check(strobe == 1'b0, "R8", "strobe before 3rd edge", int'(strobe), 0);
    idle(1);
    check(sdo_oe == 1'b1, "R8", "oe at 3rd edge", int'(sdo_oe), 1);
    check(strobe == 1'b1, req, "strobe at 3rd edge", int'(strobe), 1);
    mword = w;
    midx = 7;
    expect_bit("R4");
    idle(1);
    check(strobe == 1'b0, "R2", "strobe one cycle", int'(strobe), 0);
    check(strobe_cnt == c0 + 1, "R2", "strobe count", strobe_cnt, c0 + 1);
    word = ~w;
  endtask

  initial begin
    int c0;
    idle(5);
    check(sdo == 1'b0, "R1", "sdo in reset", int'(sdo), 0);
    check(sdo_oe == 1'b0, "R1", "oe in reset", int'(sdo_oe), 0);
    check(strobe == 1'b0, "R1", "strobe in reset", int'(strobe), 0);
    rst_n = 1'b1;
    idle(3);

    // R9: sync alone does nothing visible
    msync = 1'b1;
    idle(6);
    check(strobe_cnt == 0, "R9", "strobe on sync alone", strobe_cnt, 0);
    check(sdo_oe == 1'b0, "R9", "oe on sync alone", int'(sdo_oe), 0);
    msync = 1'b0;
    idle(4);

    // Byte mode: load, then sixteen shifts
    ten_up_load(8'hB5, "R2");
    repeat (8) dpulse("R5");
    check(sdo == mword[7], "R7", "wrap to sign bit", int'(sdo), int'(mword[7]));
    repeat (8) dpulse("R7");

    // Enable low: pad released, data clock ignored
    ten = 1'b0;
    idle(4);
    check(sdo_oe == 1'b0, "R6", "oe after enable drop", int'(sdo_oe), 0);
    repeat (2) dpulse("R5");

    // R3: enable rise without a sync, the new word must not load
    c0 = strobe_cnt;
    word = 8'h5A;
    ten = 1'b1;
    idle(4);
    check(strobe_cnt == c0, "R3", "no strobe without sync", strobe_cnt, c0);
    check(sdo_oe == 1'b1, "R6", "oe follows enable", int'(sdo_oe), 1);
    expect_bit("R3");
    repeat (3) dpulse("R3");
    ten = 1'b0;
    idle(4);

    // Bit-interleaved frame
    msync = 1'b1;
    idle(4);
    msync = 1'b0;
    idle(4);
    ten_up_load(8'h3C, "R2");
    c0 = strobe_cnt;
    for (int k = 0; k < 4; k++) begin
      dpulse("R5");
      ten = 1'b0;
      idle(4);
      dpulse("R5");
      ten = 1'b1;
      idle(4);
      expect_bit("R3");
    end
    check(strobe_cnt == c0, "R3", "no strobe on mid-word enable", strobe_cnt, c0);
    ten = 1'b0;
    dpulse("R5");
    idle(4);

    // R9: sync and enable rise together
    msync = 1'b1;
    ten_up_load(8'h81, "R9");
    msync = 1'b0;
    repeat (3) dpulse("R5");
    ten = 1'b0;
    idle(6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule